// File: doc/BRIEF.md
# Alignment-Driven DMA Transfer Sizer

The block sits in the bus-master path of a DMA channel. It receives a start address and a byte count of any length, and it turns them into a series of bus transfers. Each transfer is a single byte, a single 32-bit word, or a four-word burst. The block picks each size from the low bits of the current address and from the number of bytes still to move. Misaligned addresses first step by bytes up to a word boundary. Words then carry the address up to a 16-byte boundary, and bursts take over from there. A short tail always falls back to smaller pieces, so the count is never exceeded. Bursts begin only on 16-byte boundaries, so no burst can cross a 1 KB boundary.

Each transfer uses a request/grant/complete exchange. The block raises a request with the address and the size. It drops the request once the grant is seen, and it waits for the completion strobe. On that strobe it advances the address and the count. The following cycle it offers the next transfer, whose size is computed from the updated registers. A one-cycle done pulse marks the end of the buffer. After that, the address and the count hold until the next start.

In copy mode the block alternates between the two sides. It reads from the source with the adaptive sizes and places the returned bytes in a 16-byte holding bay. It then empties the bay to the destination in word or byte writes, chosen by the destination's own alignment. Only the source side ever bursts.

Top module: `xfer_sizer`

## Requirements
- R1: After reset req_o, busy_o and done_o are 0, and count_o is 0.
- R2: When the current address has its low four bits equal to 0000 and at least 16 bytes remain, the transfer has size_o = 2 (four-word burst) and burst_o = 1. The address then advances by 16.
- R3: When the low two address bits are 00, the R2 condition does not hold and at least 4 bytes remain, the transfer has size_o = 1 (word). The address then advances by 4.
- R4: In every other case the transfer has size_o = 0 (byte) and the address advances by 1. This covers addresses ending in 01, 10 or 11, and word-aligned addresses with fewer than 4 bytes left.
- R5: count_o starts at len_i and drops by the size of each completed source-side transfer. The sizes of all source transfers add up to exactly len_i.
- R6: req_o rises in the cycle after start_i, or in the cycle after a completion that leaves work to do. It holds its address and size unchanged until a cycle with gnt_i high. It is then low until the xdone_i completion arrives.
- R7: done_o is high for exactly one cycle, in the cycle after the final completion. A start with len_i = 0 gives the pulse in the next cycle and issues no request. Afterwards count_o reads 0 and addr_o reads src_i + len_i until the next start.
- R8: A start_i pulse while busy_o is high is ignored, and the transfer sequence under way continues unchanged.
- R9: In copy mode (copy_i = 1 at start), each source read (write_o = 0) uses the R2 to R4 sizes on the source address. The returned bytes are then written to the destination (write_o = 1) before the next read. Each write is a word when the destination address has low bits 00 and at least 4 bytes are left in the bay; otherwise it is a byte.
- R10: rdata_i holds the read bytes least significant byte first, byte k belonging to the read address + k. A copy-mode word write carries the next four source bytes in wdata_o[31:0], lowest address in bits 7:0. A byte write carries the next source byte in wdata_o[7:0].
- R11: Outside copy mode, write_o on every transfer equals dir_i as sampled at the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| copy_i | input | 1 | Copy mode select, sampled at start |
| dir_i | input | 1 | Direction for single-side mode (1 = write), sampled at start |
| src_i | input | AW | Source (or only) start address |
| dst_i | input | AW | Destination start address for copy mode |
| len_i | input | CW | Byte count |
| gnt_i | input | 1 | Bus grant for the pending request |
| xdone_i | input | 1 | Transfer complete strobe |
| rdata_i | input | 8*BAY_BYTES | Read data, byte k at bits 8k+7:8k |
| req_o | output | 1 | Transfer request |
| addr_o | output | AW | Address of the current transfer (source address when idle) |
| size_o | output | 2 | 0 byte, 1 word, 2 four-word burst |
| burst_o | output | 1 | High when size_o is a burst |
| write_o | output | 1 | Transfer direction (1 = write) |
| wdata_o | output | 32 | Write data from the bay in copy mode |
| count_o | output | CW | Source bytes remaining |
| busy_o | output | 1 | A buffer is in progress |
| done_o | output | 1 | One-cycle end-of-buffer pulse |

## Verification
Each register on the path adds one cycle. A new request, and its address and size, is due in the cycle after start_i or after the completion strobe. The request falls in the cycle after the grant. The updated count and the done pulse appear in the cycle after the final completion. The bench drives inputs and samples outputs on the falling edge. It compares each request with a transfer list that it built beforehand from the sizing rules. It inserts random grant and completion delays, and on every waiting cycle it checks that the request is held steady, or is absent.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_WORD = 2'd1,
      XS_QUAD = 2'd2
   } xs_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } xs_state_e;

   function automatic logic [4:0] xs_bytes(input xs_size_e s);
      case (s)
         XS_QUAD: xs_bytes = 5'd16;
         XS_WORD: xs_bytes = 5'd4;
         default: xs_bytes = 5'd1;
      endcase
   endfunction

endpackage

// File: rtl/xs_size_pick.sv
module xs_size_pick
   import xs_pkg::*;
#(
   parameter int CW      = 16,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic [3:0]    addr_lo,
   input  logic [CW-1:0] rem,
   input  logic          quad_ok,
   output xs_size_e      size
);

   logic word_fit;
   logic quad_fit;
   logic word_al;
   logic quad_al;

   assign word_fit = (rem >= CW'(4));
   assign quad_fit = (rem >= CW'(16));
   assign word_al  = (addr_lo[1:0] == 2'b00);
   assign quad_al  = (addr_lo == 4'b0000);

   generate
      if (QUAD_EN) begin : g_quad
         always_comb begin
            if (quad_ok && quad_al && quad_fit)
               size = XS_QUAD;
            else if (word_al && word_fit)
               size = XS_WORD;
            else
               size = XS_BYTE;
         end
      end else begin : g_noquad
         logic unused_q;
         assign unused_q = quad_ok & quad_al & quad_fit;
         always_comb begin
            if (word_al && word_fit)
               size = XS_WORD;
            else
               size = XS_BYTE;
         end
      end
   endgenerate

endmodule

// File: rtl/xs_step.sv
module xs_step #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] lval_i,
   input  logic          adv_i,
   input  logic [4:0]    inc_i,
   output logic [AW-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= lval_i;
      else if (adv_i)
         q_o <= q_o + AW'(inc_i);
   end

endmodule

// File: rtl/xs_bay.sv
module xs_bay #(
   parameter int BAY_BYTES = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load_i,
   input  logic [BAY_BYTES*8-1:0]             ldata_i,
   input  logic [$clog2(BAY_BYTES+1)-1:0]     lcnt_i,
   input  logic                               pop_i,
   input  logic [$clog2(BAY_BYTES+1)-1:0]     pcnt_i,
   output logic [$clog2(BAY_BYTES+1)-1:0]     fill_o,
   output logic [31:0]                        head_o
);

   localparam int FW = $clog2(BAY_BYTES + 1);
   localparam int DW = BAY_BYTES * 8;
   localparam int SW = FW + 3;

   logic [DW-1:0] mask;
   logic [DW-1:0] data_q;
   logic [SW-1:0] shamt;

   genvar g;
   generate
      for (g = 0; g < BAY_BYTES; g++) begin : g_mask
         assign mask[g*8 +: 8] = (FW'(g) < lcnt_i) ? 8'hFF : 8'h00;
      end
   endgenerate

   assign shamt = {pcnt_i, 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         fill_o <= '0;
      end else if (load_i) begin
         data_q <= ldata_i & mask;
         fill_o <= lcnt_i;
      end else if (pop_i) begin
         data_q <= data_q >> shamt;
         fill_o <= fill_o - pcnt_i;
      end
   end

   assign head_o = data_q[31:0];

endmodule

// File: rtl/xfer_sizer.sv
module xfer_sizer
   import xs_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CW        = 16,
   parameter int BAY_BYTES = 16,
   parameter bit QUAD_EN   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   copy_i,
   input  logic                   dir_i,
   input  logic [AW-1:0]          src_i,
   input  logic [AW-1:0]          dst_i,
   input  logic [CW-1:0]          len_i,
   input  logic                   gnt_i,
   input  logic                   xdone_i,
   input  logic [BAY_BYTES*8-1:0] rdata_i,
   output logic                   req_o,
   output logic [AW-1:0]          addr_o,
   output logic [1:0]             size_o,
   output logic                   burst_o,
   output logic                   write_o,
   output logic [31:0]            wdata_o,
   output logic [CW-1:0]          count_o,
   output logic                   busy_o,
   output logic                   done_o
);

   localparam int FW = $clog2(BAY_BYTES + 1);

   generate
      if (AW < 10) begin : g_err_aw
         $error("xfer_sizer: AW must be at least 10");
      end
      if (CW < 5 || CW < FW) begin : g_err_cw
         $error("xfer_sizer: CW too narrow");
      end
      if (BAY_BYTES < 16) begin : g_err_bay
         $error("xfer_sizer: bay must hold a full burst");
      end
   endgenerate

   xs_state_e     state_q;
   logic          copy_q;
   logic          dir_q;
   logic          wside_q;
   logic          done_q;
   logic [CW-1:0] rem_q;

   logic [AW-1:0] src_q;
   logic [AW-1:0] dst_q;
   logic [FW-1:0] fill;
   logic [31:0]   head;

   xs_size_e      size_cur;
   logic [4:0]    nbytes;
   logic [3:0]    pick_lo;
   logic [CW-1:0] pick_rem;

   logic          accept;
   logic          fin;
   logic          fin_rd;
   logic          fin_wr;
   logic          last_rd;
   logic          bay_empty;

   assign accept = (state_q == ST_IDLE) && start_i;
   assign fin    = (state_q == ST_WAIT) && xdone_i;
   assign fin_rd = fin && !wside_q;
   assign fin_wr = fin && wside_q;

   assign pick_lo  = wside_q ? dst_q[3:0] : src_q[3:0];
   assign pick_rem = wside_q ? CW'(fill) : rem_q;

   xs_size_pick #(
      .CW      (CW),
      .QUAD_EN (QUAD_EN)
   ) u_pick (
      .addr_lo (pick_lo),
      .rem     (pick_rem),
      .quad_ok (!wside_q),
      .size    (size_cur)
   );

   assign nbytes = xs_bytes(size_cur);

   xs_step #(.AW(AW)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .lval_i (src_i),
      .adv_i  (fin_rd),
      .inc_i  (nbytes),
      .q_o    (src_q)
   );

   xs_step #(.AW(AW)) u_dst (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .lval_i (dst_i),
      .adv_i  (fin_wr),
      .inc_i  (nbytes),
      .q_o    (dst_q)
   );

   xs_bay #(.BAY_BYTES(BAY_BYTES)) u_bay (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (fin_rd && copy_q),
      .ldata_i (rdata_i),
      .lcnt_i  (FW'(nbytes)),
      .pop_i   (fin_wr),
      .pcnt_i  (FW'(nbytes)),
      .fill_o  (fill),
      .head_o  (head)
   );

   assign last_rd   = (rem_q == CW'(nbytes));
   assign bay_empty = (fill == FW'(nbytes));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         copy_q  <= 1'b0;
         dir_q   <= 1'b0;
         wside_q <= 1'b0;
         done_q  <= 1'b0;
         rem_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  copy_q  <= copy_i;
                  dir_q   <= dir_i;
                  wside_q <= 1'b0;
                  rem_q   <= len_i;
                  if (len_i == '0)
                     done_q <= 1'b1;
                  else
                     state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (gnt_i)
                  state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (xdone_i) begin
                  if (!wside_q) begin
                     rem_q <= rem_q - CW'(nbytes);
                     if (copy_q) begin
                        wside_q <= 1'b1;
                        state_q <= ST_ISSUE;
                     end else if (last_rd) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_ISSUE;
                     end
                  end else begin
                     if (bay_empty) begin
                        wside_q <= 1'b0;
                        if (rem_q == '0) begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                        end else begin
                           state_q <= ST_ISSUE;
                        end
                     end else begin
                        state_q <= ST_ISSUE;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_o   = (state_q == ST_ISSUE);
   assign addr_o  = wside_q ? dst_q : src_q;
   assign size_o  = size_cur;
   assign burst_o = (size_cur == XS_QUAD);
   assign write_o = copy_q ? wside_q : dir_q;
   assign wdata_o = head;
   assign count_o = rem_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = done_q;

endmodule

// File: rtl/xs_sizer_chk.sv
module xs_sizer_chk #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          gnt_i,
   input logic          xdone_i,
   input logic          req_o,
   input logic [AW-1:0] addr_o,
   input logic [1:0]    size_o,
   input logic          burst_o,
   input logic [CW-1:0] count_o,
   input logic          busy_o,
   input logic          done_o
);

   p_burst_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && burst_o) |-> (addr_o[3:0] == 4'd0 && count_o >= CW'(16)));

   p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && size_o == 2'd1) |-> (addr_o[1:0] == 2'd0));

   p_count_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (count_o <= $past(count_o)));

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(size_o)));

   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && gnt_i) |=> !req_o);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !req_o));

   p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(xdone_i) || $past(start_i)));

endmodule

bind xfer_sizer xs_sizer_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .gnt_i   (gnt_i),
   .xdone_i (xdone_i),
   .req_o   (req_o),
   .addr_o  (addr_o),
   .size_o  (size_o),
   .burst_o (burst_o),
   .count_o (count_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/tb_xfer_sizer.sv
module tb_xfer_sizer;

   localparam int AW = 32;
   localparam int CW = 16;
   localparam int BB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          copy_i = 1'b0;
   logic          dir_i = 1'b0;
   logic [AW-1:0] src_i = '0;
   logic [AW-1:0] dst_i = '0;
   logic [CW-1:0] len_i = '0;
   logic          gnt_i = 1'b0;
   logic          xdone_i = 1'b0;
   logic [BB*8-1:0] rdata_i = '0;
   logic          req_o;
   logic [AW-1:0] addr_o;
   logic [1:0]    size_o;
   logic          burst_o;
   logic          write_o;
   logic [31:0]   wdata_o;
   logic [CW-1:0] count_o;
   logic          busy_o;
   logic          done_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   xfer_sizer #(.AW(AW), .CW(CW), .BAY_BYTES(BB)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .copy_i(copy_i),
      .dir_i(dir_i), .src_i(src_i), .dst_i(dst_i), .len_i(len_i),
      .gnt_i(gnt_i), .xdone_i(xdone_i), .rdata_i(rdata_i),
      .req_o(req_o), .addr_o(addr_o), .size_o(size_o), .burst_o(burst_o),
      .write_o(write_o), .wdata_o(wdata_o), .count_o(count_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   typedef struct {
      int unsigned addr;
      int          nb;
      bit          wr;
      bit          dchk;
      int unsigned dexp;
      int unsigned rem;
   } ent_t;

   ent_t exp_q[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
      end
   endtask

   function automatic int pick(input int unsigned a, input int unsigned r);
      if ((a % 16) == 0 && r >= 16) return 16;
      if ((a % 4) == 0 && r >= 4) return 4;
      return 1;
   endfunction

   function automatic logic [7:0] pat(input int unsigned a);
      return 8'((a * 13 + 5) & 32'hFF);
   endfunction

   task automatic build(input bit cp, input bit dr, input int unsigned s,
                        input int unsigned d0, input int unsigned len);
      int unsigned a = s;
      int unsigned r = len;
      int unsigned d = d0;
      ent_t e;
      exp_q.delete();
      while (r > 0) begin
         int n = pick(a, r);
         e.addr = a; e.nb = n; e.wr = cp ? 1'b0 : dr; e.dchk = 1'b0;
         e.dexp = 0; e.rem = r - n;
         exp_q.push_back(e);
         a += n; r -= n;
         if (cp) begin
            int b = n;
            while (b > 0) begin
               int m = ((d % 4) == 0 && b >= 4) ? 4 : 1;
               e.addr = d; e.nb = m; e.wr = 1'b1; e.dchk = 1'b1; e.rem = r;
               e.dexp = 0;
               for (int i = 0; i < m; i++)
                  e.dexp |= int'(pat(s + (d - d0) + i)) << (8 * i);
               exp_q.push_back(e);
               d += m; b -= m;
            end
         end
      end
   endtask

   task automatic run_job(input bit cp, input bit dr, input int unsigned s,
                          input int unsigned d0, input int unsigned len, input bit poke);
      build(cp, dr, s, d0, len);
      @(negedge clk);
      start_i = 1'b1; copy_i = cp; dir_i = dr;
      src_i = s; dst_i = d0; len_i = CW'(len);
      @(negedge clk);
      start_i = 1'b0;
      if (exp_q.size() == 0) begin
         chk(done_o == 1'b1, "R7 empty done", done_o, 1);
         chk(req_o == 1'b0, "R7 empty no req", req_o, 0);
         @(negedge clk);
         chk(done_o == 1'b0, "R7 pulse width", done_o, 0);
         return;
      end
      for (int i = 0; i < exp_q.size(); i++) begin
         ent_t e = exp_q[i];
         string stag = (e.nb == 16) ? "R2 size" : (e.nb == 4) ? "R3 size" : "R4 size";
         int code = (e.nb == 16) ? 2 : (e.nb == 4) ? 1 : 0;
         int k;
         int j;
         chk(req_o == 1'b1, "R6 req rise", req_o, 1);
         chk(addr_o == e.addr, e.wr && cp ? "R9 dst addr" : "R4 addr", addr_o, e.addr);
         chk(size_o == 2'(code), e.wr && cp ? "R9 wr size" : stag, size_o, code);
         chk(burst_o == (e.nb == 16), "R2 burst", burst_o, (e.nb == 16));
         chk(write_o == e.wr, cp ? "R9 side" : "R11 dir", write_o, e.wr);
         if (e.dchk) begin
            if (e.nb == 4)
               chk(wdata_o == e.dexp, "R10 word data", wdata_o, e.dexp);
            else
               chk(wdata_o[7:0] == e.dexp[7:0], "R10 byte data", wdata_o[7:0], e.dexp[7:0]);
         end
         k = $urandom % 3;
         repeat (k) begin
            @(negedge clk);
            chk(req_o && addr_o == e.addr && size_o == 2'(code), "R6 hold", addr_o, e.addr);
         end
         gnt_i = 1'b1;
         @(negedge clk);
         gnt_i = 1'b0;
         chk(req_o == 1'b0, "R6 drop", req_o, 0);
         if (poke && i == 1) begin
            start_i = 1'b1; src_i = 32'h5555; len_i = CW'(7); copy_i = ~cp;
            @(negedge clk);
            start_i = 1'b0;
            chk(req_o == 1'b0 && busy_o, "R8 start ignored", req_o, 0);
         end
         j = $urandom % 3;
         repeat (j) begin
            @(negedge clk);
            chk(req_o == 1'b0, "R6 wait", req_o, 0);
         end
         if (!e.wr || !cp) begin
            for (int b = 0; b < BB; b++)
               rdata_i[b*8 +: 8] = pat(e.addr + b);
         end
         xdone_i = 1'b1;
         @(negedge clk);
         xdone_i = 1'b0;
         chk(count_o == CW'(e.rem), "R5 count", count_o, e.rem);
         if (i == exp_q.size() - 1) begin
            chk(done_o == 1'b1 && busy_o == 1'b0, "R7 done", done_o, 1);
            @(negedge clk);
            chk(done_o == 1'b0, "R7 pulse width", done_o, 0);
            chk(count_o == '0, "R7 count hold", count_o, 0);
            chk(addr_o == s + len, "R7 addr hold", addr_o, s + len);
         end else begin
            chk(done_o == 1'b0, "R7 early done", done_o, 0);
         end
      end
   endtask

   initial begin
      repeat (1000 * 150) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      chk(req_o == 1'b0 && busy_o == 1'b0, "R1 reset req/busy", req_o, 0);
      chk(done_o == 1'b0 && count_o == '0, "R1 reset done/count", count_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1 after reset", req_o, 0);

      run_job(1'b0, 1'b0, 32'h100, 0, 64, 1'b0);
      run_job(1'b0, 1'b1, 32'h103, 0, 37, 1'b1);
      run_job(1'b0, 1'b0, 32'h3F4, 0, 40, 1'b0);
      run_job(1'b0, 1'b1, 32'h200, 0, 3, 1'b0);
      run_job(1'b0, 1'b0, 32'h7FE, 0, 1, 1'b0);
      run_job(1'b0, 1'b0, 32'h300, 0, 0, 1'b0);
      run_job(1'b0, 1'b0, 32'h1F0, 0, 23, 1'b0);
      run_job(1'b1, 1'b0, 32'h200, 32'h5013, 20, 1'b1);
      run_job(1'b1, 1'b0, 32'h1, 32'h40, 25, 1'b0);
      run_job(1'b1, 1'b0, 32'h3F0, 32'h802, 38, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule